// File: doc/BRIEF.md
# Periodic Countdown Timer with Self-Releasing Interrupt

The block counts down from a programmable 12-bit preset on a countdown tick input and raises an event each time the count runs out. After the event it reloads the preset in the same cycle and keeps counting, so the events repeat at a fixed period. A host programs the preset and five control bits through a synchronous write port. The bits are pause, reload, run, event flag and interrupt enable. A separate read address returns the control bits, the preset or the live count.

Each event sets a sticky flag that only a host write of 0 clears. If interrupt enable is set when the event occurs, the event also asserts an interrupt output enable. An asserted output enable pulls the shared active-low interrupt line low. The interrupt releases itself after a minimum width measured on a second, slow release tick. Clearing the interrupt enable bit also releases it. Clearing the flag does not. The reload bit lets software kick the counter back to the preset, which makes the block usable as a watchdog.

Top module: `fct_timer`

## Requirements
- R1: After reset, the control bits, the preset and the counter all read 0 and `irq_oe` is 0.
- R2: While the run bit is 0, the counter takes the preset value one cycle later and ignores countdown ticks.
- R3: While run is 1, pause is 0 and the preset P is nonzero, each `cnt_tick` decrements the counter. The tick that finds the counter at 1 is an expiry event and loads P, so events are P ticks apart.
- R4: While pause is 1, the counter holds its value. When pause returns to 0, counting resumes from that value with no reload.
- R5: A control write with the reload bit at 1 loads the preset into the counter in that cycle, and no expiry happens in that cycle. A control write with the reload bit at 0 leaves the counter unchanged.
- R6: Changing run from 0 to 1 always starts the countdown from the preset.
- R7: An expiry sets the flag (control bit 3). The flag stays 1 until a control write with bit 3 at 0 clears it. Writing 1 to bit 3 never sets the flag. If an expiry and a clearing write fall in the same cycle, the expiry wins.
- R8: `irq_oe` rises in the cycle after an expiry only if interrupt enable (bit 4) was already 1. Otherwise it stays 0.
- R9: Clearing the flag does not release an asserted `irq_oe`.
- R10: A control write with bit 4 at 0 makes `irq_oe` 0 on the next cycle. This release has priority over a simultaneous expiry.
- R11: An asserted `irq_oe` drops at the (REL_PERIODS+1)-th `rel_tick` after it was asserted, so it is never released at the first one.
- R12: An expiry while `irq_oe` is 1, with interrupt enable set, restarts the release tick count.
- R13: With a preset of 0, no expiry ever occurs.
- R14: The read address selects the data. Address 0 returns the control bits as {enable, flag, run, reload, pause} in bits 4..0, address 1 returns the preset, address 2 returns the counter and address 3 returns 0. A write to address 0 updates the control bits and a write to address 1 updates the preset. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_tick | input | 1 | Single-cycle countdown source tick |
| rel_tick | input | 1 | Single-cycle tick of the interrupt release time base |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 12 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 12 | Read data, combinational from the registers |
| irq_oe | output | 1 | Interrupt output enable; 1 pulls the active-low line low |

## Verification
Directed phases step through the idle hold, a full countdown period, pause and resume, reload kicks, and flag clears with 0 and with 1. They also cover interrupt assertion with the enable set and with it clear, release by tick count versus release by clearing the enable, a restart of the release count, and a zero preset. These phases separate the hold, reload and resume behaviours of the counter, and they separate the sticky flag from the self-timed interrupt line. A random phase then mixes dense writes to every address with random countdown and release ticks. This exposes the same-cycle collisions: a reload or clear against an expiry, and a release tick against a new event.

// File: rtl/fct_pkg.sv
package fct_pkg;

  typedef struct packed {
    logic ie;
    logic flag;
    logic run;
    logic kick;
    logic halt;
  } fct_ctrl_t;

  localparam int CTRL_BITS = 5;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_PRESET = 2'd1,
    ADDR_COUNT  = 2'd2,
    ADDR_NONE   = 2'd3
  } fct_addr_e;

endpackage

// File: rtl/fct_regs.sv
module fct_regs
  import fct_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             expire,
  output fct_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0] preset_q,
  output logic             kick_wr,
  output logic             ie_clr
);

  logic      ctrl_wr;
  logic      preset_wr;
  fct_ctrl_t wr_ctrl;
  fct_ctrl_t ctrl_d;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign preset_wr = wr_en && (wr_addr == ADDR_PRESET);
  assign wr_ctrl   = fct_ctrl_t'(wr_data[CTRL_BITS-1:0]);
  assign kick_wr   = ctrl_wr && wr_ctrl.kick;
  assign ie_clr    = ctrl_wr && !wr_ctrl.ie;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.halt = wr_ctrl.halt;
      ctrl_d.kick = wr_ctrl.kick;
      ctrl_d.run  = wr_ctrl.run;
      ctrl_d.ie   = wr_ctrl.ie;
      if (!wr_ctrl.flag) ctrl_d.flag = 1'b0;
    end
    if (expire) ctrl_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      preset_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (preset_wr) preset_q <= wr_data;
    end
  end

endmodule

// File: rtl/fct_counter.sv
module fct_counter
  import fct_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  fct_ctrl_t        ctrl_q,
  input  logic [CNT_W-1:0] preset_q,
  input  logic             kick_wr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  logic             load;
  logic             active;
  logic [CNT_W-1:0] cnt_d;

  assign load   = !ctrl_q.run || kick_wr;
  assign active = ctrl_q.run && !ctrl_q.halt && cnt_tick && (preset_q != '0);
  assign expire = active && !load && (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load || expire) cnt_d = preset_q;
    else if (active)    cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fct_irq.sv
module fct_irq #(
  parameter int REL_PERIODS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ie_q,
  input  logic ie_clr,
  input  logic rel_tick,
  output logic irq_q
);

  localparam int RW = $clog2(REL_PERIODS + 1);

  logic          irq_d;
  logic [RW-1:0] rel_q;
  logic [RW-1:0] rel_d;
  logic          rel_en;

  always_comb begin
    irq_d  = irq_q;
    rel_d  = rel_q;
    rel_en = 1'b0;
    if (ie_clr) begin
      irq_d  = 1'b0;
      rel_d  = '0;
      rel_en = 1'b1;
    end else if (expire && ie_q) begin
      irq_d  = 1'b1;
      rel_d  = '0;
      rel_en = 1'b1;
    end else if (irq_q && rel_tick) begin
      rel_en = 1'b1;
      if (rel_q == RW'(REL_PERIODS)) begin
        irq_d = 1'b0;
        rel_d = '0;
      end else begin
        rel_d = rel_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rel_q <= '0;
    end else begin
      irq_q <= irq_d;
      if (rel_en) rel_q <= rel_d;
    end
  end

endmodule

// File: rtl/fct_timer.sv
module fct_timer
  import fct_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int REL_PERIODS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             rel_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_oe
);

  logic [1:0]       rst_sync;
  logic             srst_n;
  fct_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] cnt_q;
  logic             kick_wr;
  logic             ie_clr;
  logic             expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  fct_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .expire   (expire),
    .ctrl_q   (ctrl_q),
    .preset_q (preset_q),
    .kick_wr  (kick_wr),
    .ie_clr   (ie_clr)
  );

  fct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .cnt_tick (cnt_tick),
    .ctrl_q   (ctrl_q),
    .preset_q (preset_q),
    .kick_wr  (kick_wr),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  fct_irq #(.REL_PERIODS(REL_PERIODS)) u_irq (
    .clk      (clk),
    .rst_n    (srst_n),
    .expire   (expire),
    .ie_q     (ctrl_q.ie),
    .ie_clr   (ie_clr),
    .rel_tick (rel_tick),
    .irq_q    (irq_oe)
  );

  always_comb begin
    unique case (fct_addr_e'(rd_addr))
      ADDR_CTRL:   rd_data = CNT_W'(ctrl_q);
      ADDR_PRESET: rd_data = preset_q;
      ADDR_COUNT:  rd_data = cnt_q;
      default:     rd_data = '0;
    endcase
  end

endmodule

// File: rtl/fct_timer_chk.sv
module fct_timer_chk
  import fct_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input fct_ctrl_t        ctrl_q,
  input logic [CNT_W-1:0] preset_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             expire,
  input logic             irq_oe
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  assert_idle_loads_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |=> cnt_q == $past(preset_q));

  assert_pause_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && ctrl_q.halt && !ctrl_wr) |=> $stable(cnt_q));

  assert_flag_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.flag) |-> $past(ctrl_wr && !wr_data[3]));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> $past(expire && ctrl_q.ie));

  assert_ie_clear_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[4]) |=> !irq_oe);

  assert_zero_preset_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_q == '0) |-> !expire);

endmodule

bind fct_timer fct_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .ctrl_q   (ctrl_q),
  .preset_q (preset_q),
  .cnt_q    (cnt_q),
  .expire   (expire),
  .irq_oe   (irq_oe)
);

// File: tb/sim_fct_timer.sv
`timescale 1ns/100ps
module sim_fct_timer;

  localparam int W  = 12;
  localparam int RP = 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_tick = 1'b0;
  logic         rel_tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         irq_oe;

  always #2.5 clk = ~clk;

  fct_timer #(.CNT_W(W), .REL_PERIODS(RP)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .rel_tick(rel_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_oe(irq_oe)
  );

  int checks = 0;
  int failures = 0;
  string req = "R1";
  bit done = 1'b0;

  // expected state: control bits {ie,flag,run,kick,halt}
  logic [4:0]   m_ctrl;
  logic [W-1:0] m_pre, m_cnt;
  logic         m_irq;
  int           m_rel;

  function automatic logic [W-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return W'(m_ctrl);
      2'd1: return m_pre;
      2'd2: return m_cnt;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input bit t, input bit r, input bit we, input logic [1:0] wa,
                       input logic [W-1:0] wd);
    bit cw, load, act, ex, clr;
    cw   = we && wa == 2'd0;
    load = !m_ctrl[2] || (cw && wd[1]);
    act  = m_ctrl[2] && !m_ctrl[0] && t && m_pre != 0;
    ex   = act && !load && m_cnt <= 1;
    clr  = cw && !wd[4];
    if (clr) begin m_irq = 0; m_rel = 0; end
    else if (ex && m_ctrl[4]) begin m_irq = 1; m_rel = 0; end
    else if (m_irq && r) begin
      if (m_rel == RP) begin m_irq = 0; m_rel = 0; end
      else m_rel++;
    end
    m_cnt = (load || ex) ? m_pre : act ? m_cnt - 1 : m_cnt;
    if (cw) begin
      m_ctrl[0] = wd[0]; m_ctrl[1] = wd[1]; m_ctrl[2] = wd[2]; m_ctrl[4] = wd[4];
      if (!wd[3]) m_ctrl[3] = 0;
    end
    if (ex) m_ctrl[3] = 1;
    if (we && wa == 2'd1) m_pre = wd;
  endtask

  task automatic observe();
    chk("irq_oe", W'(irq_oe), W'(m_irq));
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #0.2;
      chk($sformatf("read addr %0d", a), rd_data, exp_read(2'(a)));
    end
  endtask

  task automatic cyc(input bit t, input bit r, input bit we, input logic [1:0] wa,
                     input logic [W-1:0] wd);
    @(negedge clk);
    cnt_tick = t; rel_tick = r; wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    model(t, r, we, wa, wd);
    #1;
    observe();
  endtask

  task automatic idle(input int n, input bit t, input bit r);
    for (int i = 0; i < n; i++) cyc(t, r, 0, 2'd0, '0);
  endtask

  // control word {ie,flag,run,kick,halt}
  function automatic logic [W-1:0] cw(input bit ie, input bit fl, input bit run,
                                      input bit kick, input bit halt);
    return W'({ie, fl, run, kick, halt});
  endfunction

  initial begin
    #100000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_ctrl = '0; m_pre = '0; m_cnt = '0; m_irq = 0; m_rel = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    req = "R1"; observe();

    req = "R14"; cyc(0, 0, 1, 2'd0, cw(1, 1, 0, 0, 1));
    cyc(0, 0, 1, 2'd1, W'(5));
    cyc(0, 0, 1, 2'd2, W'(12'h3ff));
    cyc(0, 0, 1, 2'd3, W'(12'h7));
    req = "R2"; idle(4, 1, 0);

    req = "R6"; cyc(0, 0, 1, 2'd0, cw(1, 0, 1, 0, 0));
    req = "R3"; idle(6, 1, 0);
    req = "R8"; idle(1, 0, 0);
    req = "R9"; cyc(0, 0, 1, 2'd0, cw(1, 0, 1, 0, 0));
    req = "R11"; idle(1, 0, 1); idle(2, 0, 0); idle(1, 0, 1);
    req = "R12"; idle(5, 1, 0); idle(1, 0, 1); idle(5, 1, 0); idle(1, 0, 1); idle(1, 0, 1);
    req = "R10"; idle(5, 1, 0); cyc(0, 0, 1, 2'd0, cw(0, 1, 1, 0, 0));
    req = "R7"; cyc(0, 0, 1, 2'd0, cw(0, 1, 1, 0, 0));
    cyc(0, 0, 1, 2'd0, cw(0, 0, 1, 0, 0)); cyc(0, 0, 1, 2'd0, cw(0, 1, 1, 0, 0));
    req = "R8"; idle(6, 1, 0);
    req = "R4"; idle(2, 1, 0); cyc(0, 0, 1, 2'd0, cw(0, 1, 1, 0, 1)); idle(4, 1, 0);
    cyc(0, 0, 1, 2'd0, cw(0, 1, 1, 0, 0)); idle(2, 1, 0);
    req = "R5"; cyc(1, 0, 1, 2'd0, cw(0, 1, 1, 1, 0)); idle(2, 1, 0);
    cyc(1, 0, 1, 2'd0, cw(0, 1, 1, 0, 0)); idle(3, 1, 0);
    req = "R13"; cyc(0, 0, 1, 2'd1, '0); cyc(0, 0, 1, 2'd0, cw(1, 0, 0, 0, 0));
    cyc(0, 0, 1, 2'd0, cw(1, 0, 1, 0, 0)); idle(20, 1, 1);

    req = "R3 random";
    for (int i = 0; i < 4000; i++) begin
      bit we; logic [1:0] wa; logic [W-1:0] wd;
      we = ($urandom % 10) < 2;
      wa = 2'($urandom % 4);
      wd = (wa == 2'd1) ? W'($urandom % 9) : W'($urandom);
      if (wa == 2'd0 && ($urandom % 4) != 0) wd[2] = 1'b1;
      if (wa == 2'd0 && ($urandom % 3) != 0) wd[0] = 1'b0;
      cyc(($urandom % 2) == 1, ($urandom % 8) == 0, we, wa, wd);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule